// File: doc/BRIEF.md
# External memory clock generator

This block produces the clock that a four-bank static memory controller drives to external synchronous memories. It holds one control register, one read-timing register and one write-timing register per bank. From the bank an access targets, its direction and the bank's control bits, it decides whether the access is synchronous. It then runs a small phase state machine that divides the bus clock by a programmable ratio.

In the normal mode the memory clock toggles only while a synchronous access is active. It starts low and always finishes its current high phase before it parks low. A shared continuous mode can be switched on from bank 1's control register alone. In that mode the clock free-runs from bank 1's read-timing divider, whatever the access type or bank. A divider or enable change is picked up only when a new low phase begins, so no runt pulse reaches the pins.

The phase machine has three states: S_IDLE (clock parked low), S_LOW (counting the low phase) and S_HIGH (counting the high phase). Its transitions are:

- start, from S_IDLE to S_LOW, when the run condition appears. It latches the divider.
- rise, from S_LOW to S_HIGH, when the low count ends.
- fall, from S_HIGH to S_LOW, when the high count ends and the run condition still holds. It latches a fresh divider.
- stop, from S_LOW or S_HIGH to S_IDLE, when the run condition is gone. From S_HIGH this happens only once the high count has ended.

Top module: `mck_clock_gen`

## Requirements
- R1: After reset, reading a register returns these values:
  - the control register of bank b, at byte address 8*(b-1), reads 0x000030DB for bank 1 and 0x000030D2 for banks 2 to 4.
  - the read-timing register, at 8*(b-1)+4, reads 0x0FFFFFFF.
  - the write-timing register, at 0x104+8*(b-1), reads 0x0FFFFFFF.
  - bits 31:22 of a control register always read 0.
- R2: `acc_sync` is 1 exactly when all of these hold:
  - `acc_active` is 1.
  - the selected bank's control bit 8 (burst enable) is 1.
  - the access is a read (`acc_rnw`=1), or the bank's control bit 19 (write burst enable) is 1.
- R3: With continuous mode off, `mem_clk` stays 0 whenever no synchronous access is active, and toggles during a synchronous access.
- R4: The divide field is bits 23:20 of a timing register. Reads use the bank's read-timing field and writes use the write-timing field. A field value N gives a `mem_clk` period of N+1 bus clocks, with N=0 treated as 1. The high phase lasts floor(period/2) bus clocks.
- R5: When the synchronous access ends during a high phase, that high phase still runs its full length. `mem_clk` then stays 0.
- R6: When bank 1's control bit 20 (continuous enable) and bit 8 are both 1, `mem_clk` runs with no access active and during asynchronous accesses.
- R7: Bit 20 in the control registers of banks 2 to 4 has no effect on `mem_clk`.
- R8: In continuous mode the period comes only from bank 1's read-timing field. Other banks' fields and bank 1's write-timing field have no effect.
- R9: With bank 1's bit 8 at 0, bank 1's bit 20 does not start `mem_clk`.
- R10: A divider written during a high phase leaves that high phase unchanged. It applies from the next low phase on.
- R11: `wfifo_off` follows bank 1's control bit 21, which resets to 0. Bit 21 of banks 2 to 4 has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_active | input | 1 | External access in progress |
| acc_bank | input | 2 | Bank of the access (0 = bank 1) |
| acc_rnw | input | 1 | 1 = read, 0 = write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_clk | output | 1 | Clock to external memory |
| acc_sync | output | 1 | Current access is synchronous |
| wfifo_off | output | 1 | Write FIFO disable from bank 1 |

## Verification
The divider is exercised with even, odd and zero fields. Measured period and high time show that the ratio is N+1 and that zero is treated as one. Asynchronous reads, and writes without write burst enable, are set against synchronous reads and writes. This tells the burst-enable and write-burst rules apart, and shows whether reads and writes take their divider from the right timing register. Continuous mode is run with no access, with an async access, with another bank's sync access and with a bank 1 write. This separates the shared-divider override from each bank's own divider. Continuous enable is also tried from another bank, and from bank 1 while it is asynchronous. A divider rewrite in mid-high-phase and an access end in mid-high-phase check the no-runt rules.

// File: rtl/mck_pkg.sv
package mck_pkg;
    localparam int DATA_W = 32;

    localparam int F_BURST  = 8;
    localparam int F_WBURST = 19;
    localparam int F_CONT   = 20;
    localparam int F_WFDIS  = 21;
    localparam int DIV_LSB  = 20;

    localparam logic [DATA_W-1:0] CTRL_KEEP   = 32'h003F_FFFF;
    localparam logic [DATA_W-1:0] RST_CTRL_B1 = 32'h0000_30DB;
    localparam logic [DATA_W-1:0] RST_CTRL_BN = 32'h0000_30D2;
    localparam logic [DATA_W-1:0] RST_TIME    = 32'h0FFF_FFFF;

    localparam int BANK_STRIDE = 8;
    localparam int RT_OFFSET   = 4;
    localparam int WT_BASE     = 'h104;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } mck_state_t;
endpackage

// File: rtl/mck_regfile.sv
module mck_regfile
    import mck_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int DIV_W  = 4,
    parameter int ADDR_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [NBANK-1:0]            burst_en,
    output logic [NBANK-1:0]            wburst_en,
    output logic                        cont_req,
    output logic                        fifo_off,
    output logic [NBANK-1:0][DIV_W-1:0] rd_div,
    output logic [NBANK-1:0][DIV_W-1:0] wr_div
);
    logic [NBANK-1:0][DATA_W-1:0] ctrl_q;
    logic [NBANK-1:0][DATA_W-1:0] rt_q;
    logic [NBANK-1:0][DATA_W-1:0] wt_q;
    logic [NBANK-1:0]             hit_ctrl, hit_rt, hit_wt;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(b * BANK_STRIDE);
        localparam logic [ADDR_W-1:0] A_RT   = ADDR_W'(b * BANK_STRIDE + RT_OFFSET);
        localparam logic [ADDR_W-1:0] A_WT   = ADDR_W'(WT_BASE + b * BANK_STRIDE);
        localparam logic [DATA_W-1:0] CRST   = (b == 0) ? RST_CTRL_B1 : RST_CTRL_BN;

        assign hit_ctrl[b] = (reg_addr == A_CTRL);
        assign hit_rt[b]   = (reg_addr == A_RT);
        assign hit_wt[b]   = (reg_addr == A_WT);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[b] <= CRST;
                rt_q[b]   <= RST_TIME;
                wt_q[b]   <= RST_TIME;
            end else if (reg_we) begin
                if (hit_ctrl[b]) ctrl_q[b] <= reg_wdata & CTRL_KEEP;
                if (hit_rt[b])   rt_q[b]   <= reg_wdata;
                if (hit_wt[b])   wt_q[b]   <= reg_wdata;
            end
        end

        assign burst_en[b]  = ctrl_q[b][F_BURST];
        assign wburst_en[b] = ctrl_q[b][F_WBURST];
        assign rd_div[b]    = rt_q[b][DIV_LSB +: DIV_W];
        assign wr_div[b]    = wt_q[b][DIV_LSB +: DIV_W];
    end

    // Continuous clock and FIFO disable are taken from bank 1 only
    assign cont_req = ctrl_q[0][F_CONT];
    assign fifo_off = ctrl_q[0][F_WFDIS];

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (hit_ctrl[b]) reg_rdata = ctrl_q[b];
            if (hit_rt[b])   reg_rdata = rt_q[b];
            if (hit_wt[b])   reg_rdata = wt_q[b];
        end
    end
endmodule

// File: rtl/mck_access_decode.sv
module mck_access_decode #(
    parameter int NBANK  = 4,
    parameter int DIV_W  = 4,
    parameter int BANK_W = 2
) (
    input  logic                        acc_active,
    input  logic [BANK_W-1:0]           acc_bank,
    input  logic                        acc_rnw,
    input  logic [NBANK-1:0]            burst_en,
    input  logic [NBANK-1:0]            wburst_en,
    input  logic                        cont_req,
    input  logic [NBANK-1:0][DIV_W-1:0] rd_div,
    input  logic [NBANK-1:0][DIV_W-1:0] wr_div,
    output logic                        acc_sync,
    output logic                        cont_on,
    output logic                        run,
    output logic [DIV_W-1:0]            div_sel
);
    logic sel_burst, sel_wburst;

    assign sel_burst  = burst_en[acc_bank];
    assign sel_wburst = wburst_en[acc_bank];

    // Reads need burst enable; writes need write burst enable as well
    assign acc_sync = acc_active && sel_burst && (acc_rnw || sel_wburst);

    // Shared free-running clock needs bank 1 itself to be synchronous
    assign cont_on = cont_req && burst_en[0];
    assign run     = cont_on || acc_sync;

    always_comb begin
        if (cont_on)      div_sel = rd_div[0];
        else if (acc_rnw) div_sel = rd_div[acc_bank];
        else              div_sel = wr_div[acc_bank];
    end
endmodule

// File: rtl/mck_phase_fsm.sv
module mck_phase_fsm
    import mck_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             clk_o
);
    localparam int CNT_W = DIV_W;

    function automatic logic [DIV_W:0] period_of(input logic [DIV_W-1:0] d);
        return (d == '0) ? (DIV_W+1)'(2) : ({1'b0, d} + (DIV_W+1)'(1));
    endfunction

    function automatic logic [CNT_W-1:0] high_len(input logic [DIV_W-1:0] d);
        logic [DIV_W:0] p;
        p = period_of(d);
        return CNT_W'(p >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] low_len(input logic [DIV_W-1:0] d);
        logic [DIV_W:0] p;
        p = period_of(d);
        return CNT_W'(p - (p >> 1));
    endfunction

    mck_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [DIV_W-1:0] div_q, div_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        div_n   = div_q;
        unique case (state)
            S_IDLE: begin
                if (run) begin                       // start
                    state_n = S_LOW;
                    cnt_n   = low_len(div_in);
                    div_n   = div_in;
                end
            end
            S_LOW: begin
                if (!run) begin                      // stop
                    state_n = S_IDLE;
                end else if (cnt <= CNT_W'(1)) begin // rise
                    state_n = S_HIGH;
                    cnt_n   = high_len(div_q);
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            S_HIGH: begin
                if (cnt > CNT_W'(1)) begin
                    cnt_n = cnt - CNT_W'(1);
                end else if (run) begin              // fall
                    state_n = S_LOW;
                    cnt_n   = low_len(div_in);
                    div_n   = div_in;
                end else begin                       // stop
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            div_q <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            div_q <= div_n;
        end
    end

    // Output register: clock high only in the high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_o <= 1'b0;
        else        clk_o <= (state_n == S_HIGH);
    end

    // R5: a high phase is never cut short
    p_high_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && cnt > CNT_W'(1)) |=> (state == S_HIGH && clk_o));

    // R3: parked clock is low
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !clk_o);

    // R3: low phase drives low
    p_low_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOW) |-> !clk_o);

    // R10: latched divider only changes on entry to a low phase
    p_div_at_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> (state == S_LOW));
endmodule

// File: rtl/mck_clock_gen.sv
module mck_clock_gen
    import mck_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int DIV_W  = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_active,
    input  logic [1:0]        acc_bank,
    input  logic              acc_rnw,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_clk,
    output logic              acc_sync,
    output logic              wfifo_off
);
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [NBANK-1:0]            burst_en, wburst_en;
    logic                        cont_req, cont_on, run;
    logic [NBANK-1:0][DIV_W-1:0] rd_div, wr_div;
    logic [DIV_W-1:0]            div_sel;

    mck_regfile #(.NBANK(NBANK), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .burst_en  (burst_en),
        .wburst_en (wburst_en),
        .cont_req  (cont_req),
        .fifo_off  (wfifo_off),
        .rd_div    (rd_div),
        .wr_div    (wr_div)
    );

    mck_access_decode #(.NBANK(NBANK), .DIV_W(DIV_W), .BANK_W(BANK_W)) u_dec (
        .acc_active (acc_active),
        .acc_bank   (BANK_W'(acc_bank)),
        .acc_rnw    (acc_rnw),
        .burst_en   (burst_en),
        .wburst_en  (wburst_en),
        .cont_req   (cont_req),
        .rd_div     (rd_div),
        .wr_div     (wr_div),
        .acc_sync   (acc_sync),
        .cont_on    (cont_on),
        .run        (run),
        .div_sel    (div_sel)
    );

    mck_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_in (div_sel),
        .clk_o  (mem_clk)
    );

    // R8: shared clock takes its ratio from bank 1's read-timing field
    p_cont_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cont_on |-> (div_sel == rd_div[0]));
endmodule

// File: tb/sim_mck_clock_gen.sv
`timescale 1ns/1ps
module sim_mck_clock_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_active = 1'b0;
    logic [1:0]  acc_bank = 2'd0;
    logic        acc_rnw = 1'b1;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_clk, acc_sync, wfifo_off;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mck_clock_gen u0 (
        .clk(clk), .rst_n(rst_n), .acc_active(acc_active), .acc_bank(acc_bank),
        .acc_rnw(acc_rnw), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_clk(mem_clk), .acc_sync(acc_sync), .wfifo_off(wfifo_off)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 9'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 9'(a);
        #0.5;
        check(req, reg_rdata, exp);
    endtask

    task automatic access(input logic act, input int bank, input logic rnw);
        @(negedge clk);
        acc_active = act; acc_bank = 2'(bank); acc_rnw = rnw;
    endtask

    task automatic watch(input int n, output int rises, output int per, output int hi);
        int since, hrun;
        bit seen;
        logic prev;
        rises = 0; per = 0; hi = 0; since = 0; hrun = 0; seen = 0; prev = mem_clk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            since++;
            if (mem_clk && !prev) begin
                if (seen) per = since;
                seen = 1; since = 0; rises++; hrun = 1;
            end else if (mem_clk) begin
                hrun++;
            end
            if (!mem_clk && prev) hi = hrun;
            prev = mem_clk;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = mem_clk;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_clk && !prev) return;
            prev = mem_clk;
        end
        check("wait_rise", 0, 1);
    endtask

    task automatic t_reset();
        for (int b = 0; b < 4; b++) begin
            rd_check("R1 ctrl", 8*b, (b == 0) ? 32'h30DB : 32'h30D2);
            rd_check("R1 rtime", 8*b + 4, 32'h0FFF_FFFF);
            rd_check("R1 wtime", 'h104 + 8*b, 32'h0FFF_FFFF);
        end
        check("R3 reset clk", mem_clk, 0);
        check("R2 reset sync", acc_sync, 0);
        check("R11 reset fifo", wfifo_off, 0);
        wr(8, 32'hFFFF_FFFF);
        rd_check("R1 reserved bits", 8, 32'h003F_FFFF);
        wr(8, 32'h30D2);
    endtask

    task automatic t_async_read();
        int r, p, h;
        access(1, 1, 1);
        #0.5; check("R2 async read", acc_sync, 0);
        watch(40, r, p, h);
        check("R3 no clock async", r, 0);
        access(0, 1, 1);
    endtask

    task automatic t_sync_read();
        int r, p, h;
        wr(8, 32'h30D2 | 32'h100);
        wr(12, 32'd3 << 20);
        access(1, 1, 1);
        #0.5; check("R2 sync read", acc_sync, 1);
        watch(60, r, p, h);
        check("R3 toggles", r > 5, 1);
        check("R4 period div3", p, 4);
        check("R4 high div3", h, 2);
        wr(12, 32'd0);
        watch(40, r, p, h);
        check("R4 period div0", p, 2);
        check("R4 high div0", h, 1);
        wr(12, 32'd4 << 20);
        watch(60, r, p, h);
        check("R4 period div4", p, 5);
        check("R4 high div4", h, 2);
        access(0, 1, 1);
        watch(20, r, p, h);
        watch(30, r, p, h);
        check("R3 stopped", r, 0);
    endtask

    task automatic t_write();
        int r, p, h;
        access(1, 1, 0);
        #0.5; check("R2 write no wburst", acc_sync, 0);
        watch(40, r, p, h);
        check("R2 async write no clk", r, 0);
        access(0, 1, 0);
        wr(8, 32'h30D2 | 32'h100 | (32'd1 << 19));
        wr('h10C, 32'd5 << 20);
        access(1, 1, 0);
        #0.5; check("R2 write sync", acc_sync, 1);
        watch(60, r, p, h);
        check("R4 write period", p, 6);
        check("R4 write high", h, 3);
        access(0, 1, 0);
        watch(30, r, p, h);
    endtask

    task automatic t_stop_mid_high();
        int hi_total, r, p, h;
        wr(12, 32'd7 << 20);
        access(1, 1, 1);
        wait_rise();
        acc_active = 1'b0;
        hi_total = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_clk) hi_total++;
        end
        check("R5 full high", hi_total, 4);
        watch(40, r, p, h);
        check("R5 stays low", r, 0);
    endtask

    task automatic t_continuous();
        int r, p, h;
        wr(0, 32'h30DB | 32'h100 | (32'd1 << 20));
        wr(4, 32'd2 << 20);
        watch(20, r, p, h);
        watch(40, r, p, h);
        check("R6 idle running", p, 3);
        check("R6 idle high", h, 1);
        access(1, 2, 1);
        #0.5; check("R2 bank3 async", acc_sync, 0);
        watch(40, r, p, h);
        check("R6 async running", p, 3);
        access(1, 1, 1);
        watch(40, r, p, h);
        check("R8 other bank div", p, 3);
        access(1, 0, 0);
        watch(40, r, p, h);
        check("R8 bank1 write div", p, 3);
        access(0, 0, 1);
    endtask

    task automatic t_div_change();
        int hi_total, r, p, h;
        wr(4, 32'd7 << 20);
        watch(40, r, p, h);
        check("R10 before", p, 8);
        wait_rise();
        hi_total = 1;
        @(negedge clk);
        if (mem_clk) hi_total++;
        reg_we = 1'b1; reg_addr = 9'd4; reg_wdata = 32'd1 << 20;
        @(negedge clk);
        if (mem_clk) hi_total++;
        reg_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (mem_clk) hi_total++;
            else break;
        end
        check("R10 old high kept", hi_total, 4);
        watch(30, r, p, h);
        check("R10 new period", p, 2);
    endtask

    task automatic t_cont_gating();
        int r, p, h;
        wr(0, 32'h30DB | (32'd1 << 20));
        watch(20, r, p, h);
        watch(30, r, p, h);
        check("R9 bank1 async no clk", r, 0);
        wr(0, 32'h30DB);
        wr(16, 32'h30D2 | 32'h100 | (32'd1 << 20));
        watch(20, r, p, h);
        watch(30, r, p, h);
        check("R7 bank3 cont ignored", r, 0);
    endtask

    task automatic t_fifo();
        wr(8, 32'h30D2 | (32'd1 << 21));
        @(negedge clk);
        check("R11 bank2 ignored", wfifo_off, 0);
        wr(0, 32'h30DB | (32'd1 << 21));
        @(negedge clk);
        check("R11 bank1 honoured", wfifo_off, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_async_read();
        t_sync_read();
        t_write();
        t_stop_mid_high();
        t_continuous();
        t_div_change();
        t_cont_gating();
        t_fifo();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule